// File: doc/BRIEF.md
# Conversion Result Limit Monitor

This block watches the stream of finished conversion results from a multi-channel converter. Each result comes with a channel index and a signed, left-justified 16-bit sample. The block compares the sample with the low and high limits held for that channel. It also subtracts the channel's offset and tracks whether the sign of the corrected value changes from one conversion of that channel to the next. Every violation sets a sticky per-channel status bit.

Three summary interrupt flags, one each for low limit, high limit and sign change, are raised while any status bit of their kind is set. Each flag is also gated by its own enable. Software writes the limits, the offsets and the enables through a simple register bus, reads them back, and clears status bits by writing ones. A check is switched on for a channel purely by the values in that channel's registers, so no separate per-check enable bits exist.

Top module: `rlm_limit_monitor`

## Requirements
- R1: After reset every status bit and every interrupt flag is 0, every low limit and offset reads 0000h, every high limit reads 7FF8h and the control register reads 0.
- R2: When a channel's low limit is not 0000h, a conversion on that channel whose sample is below the limit (signed compare) sets that channel's low status bit on the clock edge that samples the strobe. A sample equal to the limit sets nothing, and with the limit at 0000h nothing is set.
- R3: When a channel's high limit is not 7FF8h, a conversion whose sample is above the limit (signed compare) sets that channel's high status bit on the same edge. A sample equal to the limit sets nothing, and with the limit at 7FF8h nothing is set.
- R4: When a channel's offset is above 0000h as a signed value, the corrected result is the sample minus the offset, saturated to the signed 16-bit range, with bits 2:0 forced to 0. A change of its sign (negative versus non-negative) between two consecutive conversions of that channel sets the channel's zero-crossing status bit. With the offset at 0000h no bit is set.
- R5: The first conversion of a channel after reset, and the first one after any write to that channel's offset, only records the sign and never sets a zero-crossing bit.
- R6: Status bits are sticky. A bus write to a status register clears the bits whose data bits are 1. When a conversion sets a bit in the same cycle that a write clears it, the bit stays set.
- R7: Each summary interrupt is 1 exactly when its control enable is 1 and at least one status bit of its kind is set. The flag stays up until every set bit of that kind has been cleared.
- R8: A conversion touches only the status bits and stored sign of the channel it names. Without a result strobe no status bit is set.
- R9: Bus address bits [5:3] select the register group: 0 low limit, 1 high limit, 2 offset, 3 low status, 4 high status, 5 zero-crossing status, 6 control. Bits [2:0] select the channel for groups 0 to 2. Status reads return the 8-bit vector in bits [7:0]. The control bits are low enable in bit 0, high enable in bit 1 and zero-crossing enable in bit 2. Writes take effect on the clock edge, and reads are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_vld | input | 1 | Conversion result strobe |
| res_ch | input | 3 | Channel of the result |
| res_data | input | 16 | Signed left-justified sample |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register address (group, channel) |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for bus_addr |
| low_stat | output | 8 | Per-channel low-limit status |
| high_stat | output | 8 | Per-channel high-limit status |
| zc_stat | output | 8 | Per-channel zero-crossing status |
| low_irq | output | 1 | Low-limit summary interrupt |
| high_irq | output | 1 | High-limit summary interrupt |
| zc_irq | output | 1 | Zero-crossing summary interrupt |

## Verification
The hardest situation to reach is a sign change that is only visible because of saturation. With the offset at 7FF8h and the most negative sample, a wrapped subtraction would come out positive, and only a saturated one stays negative. The stimulus first sends a zero-valued corrected result on that channel and then that extreme sample. Two more cases need exact cycle alignment at the ports. One is a conversion that sets a bit in the very cycle a write-one clears it. The other is a rewrite of the offset that must discard the stored sign. The bench drives both through one step that asserts the strobe and the bus write in the same cycle.

// File: rtl/rlm_pkg.sv
package rlm_pkg;

  typedef enum logic [2:0] {
    GRP_LOW   = 3'd0,
    GRP_HIGH  = 3'd1,
    GRP_OFF   = 3'd2,
    GRP_SLOW  = 3'd3,
    GRP_SHIGH = 3'd4,
    GRP_SZC   = 3'd5,
    GRP_CTRL  = 3'd6
  } rlm_grp_e;

  localparam int CTRL_LOW_EN  = 0;
  localparam int CTRL_HIGH_EN = 1;
  localparam int CTRL_ZC_EN   = 2;
  localparam int CTRL_W       = 3;

  // Outcome of checking one conversion against its channel's registers.
  typedef struct packed {
    logic low_hit;
    logic high_hit;
    logic zc_act;
    logic neg;
  } rlm_eval_t;

endpackage

// File: rtl/rlm_regfile.sv
module rlm_regfile
  import rlm_pkg::*;
#(
  parameter int  NCH = 8,
  parameter int  DW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  rlm_grp_e                 wr_grp,
  input  logic [CHW-1:0]           wr_ch,
  input  logic [DW-1:0]            wr_data,
  output logic [NCH-1:0][DW-1:0]   low_lim,
  output logic [NCH-1:0][DW-1:0]   high_lim,
  output logic [NCH-1:0][DW-1:0]   off_val,
  output logic [CTRL_W-1:0]        ctrl_en,
  output logic [NCH-1:0]           off_wr
);

  // Value that leaves high-limit checking switched off: largest positive
  // left-justified sample (bits 2:0 clear).
  localparam logic [DW-1:0] HIGH_IDLE = {1'b0, {(DW-4){1'b1}}, 3'b000};

  logic ctrl_we;

  always_comb begin
    ctrl_we = wr_en && (wr_grp == GRP_CTRL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en <= '0;
    end else if (ctrl_we) begin
      ctrl_en <= wr_data[CTRL_W-1:0];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic ch_sel;
    logic low_we;
    logic high_we;
    logic off_we;

    always_comb begin
      ch_sel  = wr_en && (wr_ch == CHW'(c));
      low_we  = ch_sel && (wr_grp == GRP_LOW);
      high_we = ch_sel && (wr_grp == GRP_HIGH);
      off_we  = ch_sel && (wr_grp == GRP_OFF);
    end

    assign off_wr[c] = off_we;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        low_lim[c] <= '0;
      end else if (low_we) begin
        low_lim[c] <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        high_lim[c] <= HIGH_IDLE;
      end else if (high_we) begin
        high_lim[c] <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_val[c] <= '0;
      end else if (off_we) begin
        off_val[c] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/rlm_eval.sv
module rlm_eval
  import rlm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] sample,
  input  logic [DW-1:0] low_lim,
  input  logic [DW-1:0] high_lim,
  input  logic [DW-1:0] off_val,
  output rlm_eval_t     ev
);

  localparam logic [DW-1:0] HIGH_IDLE = {1'b0, {(DW-4){1'b1}}, 3'b000};

  logic              low_act;
  logic              high_act;
  logic              zc_act;
  logic signed [DW:0] diff;

  always_comb begin
    low_act  = (low_lim != '0);
    high_act = (high_lim != HIGH_IDLE);
    zc_act   = !off_val[DW-1] && (off_val != '0);

    // One extra bit holds the exact difference. Its sign equals the sign of
    // the saturated, low-bit-cleared corrected result, so no saturator is
    // needed for the crossing decision.
    diff = $signed({sample[DW-1], sample}) - $signed({off_val[DW-1], off_val});

    ev.low_hit  = low_act  && ($signed(sample) < $signed(low_lim));
    ev.high_hit = high_act && ($signed(sample) > $signed(high_lim));
    ev.zc_act   = zc_act;
    ev.neg      = (diff < 0);
  end

endmodule

// File: rtl/rlm_status.sv
module rlm_status
  import rlm_pkg::*;
#(
  parameter int  NCH = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cv_vld,
  input  logic [CHW-1:0] cv_ch,
  input  rlm_eval_t      ev,
  input  logic [NCH-1:0] clr_low,
  input  logic [NCH-1:0] clr_high,
  input  logic [NCH-1:0] clr_zc,
  input  logic [NCH-1:0] off_wr,
  output logic [NCH-1:0] low_stat,
  output logic [NCH-1:0] high_stat,
  output logic [NCH-1:0] zc_stat
);

  logic [NCH-1:0] cv_sel;
  logic [NCH-1:0] zc_set;
  logic [NCH-1:0] low_d, high_d, zc_d;
  logic [NCH-1:0] sgn_q, sgn_d;
  logic [NCH-1:0] sval_q, sval_d;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb begin
      cv_sel[c] = cv_vld && (cv_ch == CHW'(c));
      zc_set[c] = cv_sel[c] && ev.zc_act && sval_q[c] && (sgn_q[c] != ev.neg);
      sgn_d[c]  = cv_sel[c] ? ev.neg : sgn_q[c];
      // An offset write discards the stored sign, even on a converting cycle.
      if (off_wr[c]) begin
        sval_d[c] = 1'b0;
      end else if (cv_sel[c]) begin
        sval_d[c] = 1'b1;
      end else begin
        sval_d[c] = sval_q[c];
      end
    end
  end

  // A hardware set is ORed in after the clear, so it wins.
  always_comb begin
    low_d  = (low_stat  & ~clr_low)  | (cv_sel & {NCH{ev.low_hit}});
    high_d = (high_stat & ~clr_high) | (cv_sel & {NCH{ev.high_hit}});
    zc_d   = (zc_stat   & ~clr_zc)   | zc_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_stat  <= '0;
      high_stat <= '0;
      zc_stat   <= '0;
      sgn_q     <= '0;
      sval_q    <= '0;
    end else begin
      low_stat  <= low_d;
      high_stat <= high_d;
      zc_stat   <= zc_d;
      sgn_q     <= sgn_d;
      sval_q    <= sval_d;
    end
  end

endmodule

// File: rtl/rlm_limit_monitor.sv
module rlm_limit_monitor
  import rlm_pkg::*;
#(
  parameter int  NCH = 8,
  parameter int  DW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = CHW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           res_vld,
  input  logic [CHW-1:0] res_ch,
  input  logic [DW-1:0]  res_data,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] low_stat,
  output logic [NCH-1:0] high_stat,
  output logic [NCH-1:0] zc_stat,
  output logic           low_irq,
  output logic           high_irq,
  output logic           zc_irq
);

  rlm_grp_e             bus_grp;
  logic [CHW-1:0]       bus_ch;
  logic [NCH-1:0][DW-1:0] low_lim, high_lim, off_val;
  logic [CTRL_W-1:0]    ctrl_en;
  logic [NCH-1:0]       off_wr;
  logic [NCH-1:0]       clr_low, clr_high, clr_zc;
  rlm_eval_t            ev;

  always_comb begin
    bus_grp = rlm_grp_e'(bus_addr[AW-1:CHW]);
    bus_ch  = bus_addr[CHW-1:0];
  end

  always_comb begin
    clr_low  = (bus_we && bus_grp == GRP_SLOW)  ? bus_wdata[NCH-1:0] : '0;
    clr_high = (bus_we && bus_grp == GRP_SHIGH) ? bus_wdata[NCH-1:0] : '0;
    clr_zc   = (bus_we && bus_grp == GRP_SZC)   ? bus_wdata[NCH-1:0] : '0;
  end

  rlm_regfile #(.NCH(NCH), .DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_we),
    .wr_grp   (bus_grp),
    .wr_ch    (bus_ch),
    .wr_data  (bus_wdata),
    .low_lim  (low_lim),
    .high_lim (high_lim),
    .off_val  (off_val),
    .ctrl_en  (ctrl_en),
    .off_wr   (off_wr)
  );

  rlm_eval #(.DW(DW)) u_eval (
    .sample   (res_data),
    .low_lim  (low_lim[res_ch]),
    .high_lim (high_lim[res_ch]),
    .off_val  (off_val[res_ch]),
    .ev       (ev)
  );

  rlm_status #(.NCH(NCH)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .cv_vld    (res_vld),
    .cv_ch     (res_ch),
    .ev        (ev),
    .clr_low   (clr_low),
    .clr_high  (clr_high),
    .clr_zc    (clr_zc),
    .off_wr    (off_wr),
    .low_stat  (low_stat),
    .high_stat (high_stat),
    .zc_stat   (zc_stat)
  );

  always_comb begin
    low_irq  = ctrl_en[CTRL_LOW_EN]  && (low_stat  != '0);
    high_irq = ctrl_en[CTRL_HIGH_EN] && (high_stat != '0);
    zc_irq   = ctrl_en[CTRL_ZC_EN]   && (zc_stat   != '0);
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_grp)
      GRP_LOW:   bus_rdata = low_lim[bus_ch];
      GRP_HIGH:  bus_rdata = high_lim[bus_ch];
      GRP_OFF:   bus_rdata = off_val[bus_ch];
      GRP_SLOW:  bus_rdata[NCH-1:0] = low_stat;
      GRP_SHIGH: bus_rdata[NCH-1:0] = high_stat;
      GRP_SZC:   bus_rdata[NCH-1:0] = zc_stat;
      GRP_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_en;
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rlm_limit_monitor_chk.sv
module rlm_limit_monitor_chk
  import rlm_pkg::*;
#(
  parameter int  NCH = 8,
  parameter int  DW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = CHW + 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           res_vld,
  input logic [CHW-1:0] res_ch,
  input logic [DW-1:0]  res_data,
  input logic           bus_we,
  input logic [AW-1:0]  bus_addr,
  input logic [DW-1:0]  bus_wdata,
  input logic [DW-1:0]  bus_rdata,
  input logic [NCH-1:0] low_stat,
  input logic [NCH-1:0] high_stat,
  input logic [NCH-1:0] zc_stat,
  input logic           low_irq,
  input logic           high_irq,
  input logic           zc_irq
);

  logic wr_slow, wr_shigh;

  always_comb begin
    wr_slow  = bus_we && (bus_addr[AW-1:CHW] == GRP_SLOW);
    wr_shigh = bus_we && (bus_addr[AW-1:CHW] == GRP_SHIGH);
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (low_stat == '0 && high_stat == '0 && zc_stat == '0 &&
                !low_irq && !high_irq && !zc_irq));

  p_low_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_slow |=> ((low_stat & $past(low_stat)) == $past(low_stat)));

  p_high_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_shigh |=> ((high_stat & $past(high_stat)) == $past(high_stat)));

  p_low_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_slow && !res_vld) |=> ((low_stat & $past(bus_wdata[NCH-1:0])) == '0));

  p_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |=> (((low_stat & ~$past(low_stat)) == '0) &&
                  ((high_stat & ~$past(high_stat)) == '0) &&
                  ((zc_stat & ~$past(zc_stat)) == '0)));

  p_one_channel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> $onehot0((low_stat & ~$past(low_stat)) |
                         (high_stat & ~$past(high_stat)) |
                         (zc_stat & ~$past(zc_stat))));

  p_low_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    low_irq |-> (low_stat != '0));

  p_high_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    high_irq |-> (high_stat != '0));

  p_zc_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zc_irq |-> (zc_stat != '0));

endmodule

bind rlm_limit_monitor rlm_limit_monitor_chk #(.NCH(NCH), .DW(DW)) i_chk (.*);

// File: tb/test_rlm_limit_monitor.sv
`timescale 1ns/1ps
module test_rlm_limit_monitor;

  localparam int NCH = 8;
  localparam int DW  = 16;
  localparam int EW  = 3*NCH + 3;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           res_vld;
  logic [2:0]     res_ch;
  logic [DW-1:0]  res_data;
  logic           bus_we;
  logic [5:0]     bus_addr;
  logic [DW-1:0]  bus_wdata;
  logic [DW-1:0]  bus_rdata;
  logic [NCH-1:0] low_stat, high_stat, zc_stat;
  logic           low_irq, high_irq, zc_irq;

  always #2 clk = ~clk;

  rlm_limit_monitor #(.NCH(NCH), .DW(DW)) i_rlm_limit_monitor (.*);

  // Reference model state
  logic [DW-1:0]  m_low [NCH];
  logic [DW-1:0]  m_high[NCH];
  logic [DW-1:0]  m_off [NCH];
  logic [2:0]     m_ctrl;
  logic [NCH-1:0] m_ls, m_hs, m_zs, m_sgn, m_sval;

  logic [EW-1:0]  exp_q[$];
  string          tag_q[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  function automatic logic [5:0] adr(input int grp, input int ch);
    return {grp[2:0], ch[2:0]};
  endfunction

  function automatic logic [EW-1:0] model_out();
    return {m_zs, m_hs, m_ls,
            m_ctrl[2] & (m_zs != 0), m_ctrl[1] & (m_hs != 0), m_ctrl[0] & (m_ls != 0)};
  endfunction

  // One cycle of stimulus: optional conversion and optional bus write.
  task automatic step(input bit v, input int ch, input logic [DW-1:0] s,
                      input bit we, input logic [5:0] a, input logic [DW-1:0] wd,
                      input string tag);
    logic [NCH-1:0] set_l, set_h, set_z;
    int d, g, wc;
    bit neg;
    @(negedge clk);
    res_vld = v; res_ch = ch[2:0]; res_data = s;
    bus_we = we; bus_addr = a; bus_wdata = wd;
    set_l = '0; set_h = '0; set_z = '0;
    if (v) begin
      if (m_low[ch] != 16'h0000 && $signed(s) < $signed(m_low[ch])) set_l[ch] = 1'b1;
      if (m_high[ch] != 16'h7FF8 && $signed(s) > $signed(m_high[ch])) set_h[ch] = 1'b1;
      d = int'($signed(s)) - int'($signed(m_off[ch]));
      if (d > 32767) d = 32767;
      if (d < -32768) d = -32768;
      d = d & ~7;
      neg = (d < 0);
      if ($signed(m_off[ch]) > 0 && m_sval[ch] && (m_sgn[ch] != neg)) set_z[ch] = 1'b1;
      m_sgn[ch] = neg;
      m_sval[ch] = 1'b1;
    end
    if (we) begin
      g = int'(a[5:3]); wc = int'(a[2:0]);
      case (g)
        0: m_low[wc] = wd;
        1: m_high[wc] = wd;
        2: begin m_off[wc] = wd; m_sval[wc] = 1'b0; end
        3: m_ls = m_ls & ~wd[NCH-1:0];
        4: m_hs = m_hs & ~wd[NCH-1:0];
        5: m_zs = m_zs & ~wd[NCH-1:0];
        6: m_ctrl = wd[2:0];
        default: ;
      endcase
    end
    m_ls = m_ls | set_l;
    m_hs = m_hs | set_h;
    m_zs = m_zs | set_z;
    @(posedge clk);
    #1;
    res_vld = 1'b0; bus_we = 1'b0;
    exp_q.push_back(model_out());
    tag_q.push_back(tag);
  endtask

  task automatic conv(input int ch, input logic [DW-1:0] s, input string tag);
    step(1'b1, ch, s, 1'b0, 6'd0, 16'h0, tag);
  endtask

  task automatic wr(input logic [5:0] a, input logic [DW-1:0] wd, input string tag);
    step(1'b0, 0, 16'h0, 1'b1, a, wd, tag);
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    n_chk++;
    if (bus_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: read %h got %h expected %h", tag, a, bus_rdata, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [EW-1:0] e;
      logic [EW-1:0] got;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      got = {zc_stat, high_stat, low_stat, zc_irq, high_irq, low_irq};
      n_chk++;
      if (got !== e) begin
        n_fail++;
        $display("FAIL %s: outputs got %h expected %h", t, got, e);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; res_vld = 1'b0; res_ch = '0; res_data = '0;
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    for (int i = 0; i < NCH; i++) begin
      m_low[i] = 16'h0000; m_high[i] = 16'h7FF8; m_off[i] = 16'h0000;
    end
    m_ctrl = '0; m_ls = '0; m_hs = '0; m_zs = '0; m_sgn = '0; m_sval = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state at ports and in the registers
    step(1'b0, 0, 16'h0, 1'b0, 6'd0, 16'h0, "R1 reset outputs");
    rd_chk(adr(0, 0), 16'h0000, "R1 low reset");
    rd_chk(adr(1, 5), 16'h7FF8, "R1 high reset");
    rd_chk(adr(2, 7), 16'h0000, "R1 offset reset");
    rd_chk(adr(6, 0), 16'h0000, "R1 control reset");

    // R2: low limit
    conv(0, 16'h1000, "R2 low limit idle at 0000h");
    wr(adr(0, 0), 16'h2000, "R9 write low limit");
    rd_chk(adr(0, 0), 16'h2000, "R9 low limit readback");
    conv(0, 16'h2000, "R2 equal to low limit");
    conv(0, 16'h1000, "R2 below low limit");

    // R3: high limit
    conv(2, 16'h7FFF, "R3 high limit idle at 7FF8h");
    wr(adr(1, 1), 16'h4000, "R9 write high limit");
    conv(1, 16'h4000, "R3 equal to high limit");
    conv(1, 16'h4008, "R3 above high limit");

    // R6: sticky and write-one clear, set wins
    wr(adr(3, 0), 16'h0001, "R6 clear low bit 0");
    rd_chk(adr(3, 0), 16'h0000, "R6 low status readback");
    conv(0, 16'h1000, "R6 set low bit 0 again");
    conv(0, 16'h3000, "R6 bit stays set on passing sample");
    step(1'b1, 0, 16'h1000, 1'b1, adr(3, 0), 16'h0001, "R6 set wins over clear");
    wr(adr(3, 0), 16'h00FF, "R6 clear all low bits");

    // R4 / R5: zero crossing
    wr(adr(2, 2), 16'h1000, "R9 write offset");
    conv(2, 16'h2000, "R5 first conversion stores sign");
    conv(2, 16'h0800, "R4 sign change sets zero crossing");
    wr(adr(5, 0), 16'h0004, "R6 clear zero crossing bit 2");
    wr(adr(2, 2), 16'h1000, "R5 offset rewrite");
    conv(2, 16'h2000, "R5 first after offset write");
    conv(2, 16'h3000, "R4 same sign no crossing");
    wr(adr(2, 3), 16'h7FF8, "R9 write offset max");
    conv(3, 16'h7FF8, "R5 zero corrected result stored");
    conv(3, 16'h8000, "R4 saturated negative result crosses");
    conv(5, 16'h0100, "R4 offset 0000h disables");
    conv(5, 16'hF000, "R4 offset 0000h sign change ignored");

    // R7: summary interrupts
    wr(adr(6, 0), 16'h0007, "R7 enable all summaries");
    rd_chk(adr(6, 0), 16'h0007, "R9 control readback");
    wr(adr(0, 4), 16'h2000, "R9 low limit ch4");
    conv(4, 16'h1000, "R8 only channel 4 affected");
    conv(0, 16'h1000, "R7 two low bits set");
    wr(adr(3, 0), 16'h0001, "R7 irq holds with one bit left");
    wr(adr(3, 0), 16'h0010, "R7 irq drops when all cleared");
    wr(adr(4, 0), 16'h0002, "R7 high irq drops");
    wr(adr(6, 0), 16'h0000, "R7 disable masks zc irq");
    rd_chk(adr(5, 0), 16'h0008, "R7 zc status still set");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule